// File: doc/BRIEF.md
# PLL Divider Configuration and Lock Timer

This block is the register-level model of a phase-locked loop control unit. Software programs a lock-time count and a control word that carries the predivider P, the feedback multiplier M, the post-divider exponent S and an enable bit. The block does not generate a clock. It tracks when the loop would be settled and reports that through a locked flag. It also reports the nominal output frequency that the programmed dividers would produce.

When a control write changes any of P, M or S, the lock counter is reloaded from the lock-time register and the locked flag drops. The counter then counts down once per reference-clock tick. The flag rises when the counter has reached zero while the loop is enabled. Software is expected to program a lock time of P x 250 reference cycles before it changes the dividers. For example, the (P=3, M=175, S=0) setting with a 24 MHz reference gives a nominal 1400 MHz. Accesses use a single-cycle write strobe, a one-bit word address and a read port that reflects the selected word at once.

Top module: `pll_cfg_unit`

## Requirements
- R1: After reset both register words read 0, `pll_locked` is 0 and `freq_mhz` is 0.
- R2: Address 0 is the lock-time word. A write stores bits 19:0, and a read returns them with bits 31:20 as 0.
- R3: Address 1 is the control word: S in bits 2:0, P in bits 13:8, M in bits 25:16 and enable in bit 31. Bits 30, 28:26, 15:14 and 7:3 are not stored and read 0.
- R4: A control write that changes P, M or S clears the locked flag at that clock edge and reloads the counter with the lock time L. With a tick on every cycle, the flag reads 1 exactly L+1 edges after the write edge and not before. For L=0 that is one edge.
- R5: The counter moves only on cycles where `ref_tick` is 1. Once it has reached zero, the flag sets at the next edge whether or not a tick is present.
- R6: While enable is 0 the locked flag is 0 and the counter keeps its value. Enabling again with the same P, M and S resumes the count from where it stopped.
- R7: Writes to bit 29 of the control word have no effect. Bit 29 always reads the locked flag.
- R8: A control write that leaves P, M and S unchanged, with enable 1, does not disturb a set locked flag.
- R9: `freq_mhz` equals floor(M x REF_MHZ / (P x 2^S)), and 0 when P is 0.
- R10: The `pll_locked` port and bit 29 of the control word always agree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 1 | Word select: 0 lock time, 1 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word, combinational |
| ref_tick | input | 1 | One pulse per reference-clock period |
| pll_locked | output | 1 | Loop settled flag |
| freq_mhz | output | 16 | Nominal output frequency in MHz |

## Verification
The bench keeps the default parameters: a 24 MHz reference, a 20-bit lock field and a 16-bit frequency result. This range covers the full set of supported divider triplets, up to the 1700 MHz point. Small lock times (0, 3 and 10) allow each countdown to be checked edge by edge. This includes the pause and resume under enable and the stall while ticks are absent. A full-width lock value is still written and read back to cover the 20-bit field boundary.

// File: rtl/pll_pkg.sv
package pll_pkg;
    parameter int unsigned DATA_W     = 32;
    parameter int unsigned LOCK_W     = 20;
    parameter int unsigned S_W        = 3;
    parameter int unsigned P_W        = 6;
    parameter int unsigned M_W        = 10;
    parameter int unsigned S_LSB      = 0;
    parameter int unsigned P_LSB      = 8;
    parameter int unsigned M_LSB      = 16;
    parameter int unsigned LOCKED_BIT = 29;
    parameter int unsigned EN_BIT     = 31;

    typedef struct packed {
        logic           en;
        logic [M_W-1:0] m;
        logic [P_W-1:0] p;
        logic [S_W-1:0] s;
    } pll_ctrl_t;
endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
    import pll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [LOCK_W-1:0] lock_time,
    output pll_ctrl_t         ctrl,
    output logic              en_next,
    output logic              restart
);
    typedef struct packed {
        logic [LOCK_W-1:0] lock_time;
        pll_ctrl_t         ctrl;
    } regs_t;

    regs_t     regs_d, regs_q;
    pll_ctrl_t wr_ctrl;
    logic      spare_unused;

    always_comb begin
        wr_ctrl.en = wdata[EN_BIT];
        wr_ctrl.m  = wdata[M_LSB +: M_W];
        wr_ctrl.p  = wdata[P_LSB +: P_W];
        wr_ctrl.s  = wdata[S_LSB +: S_W];
        spare_unused = ^wdata;
    end

    always_comb begin
        regs_d  = regs_q;
        restart = 1'b0;
        if (wr && !addr) begin
            regs_d.lock_time = wdata[LOCK_W-1:0];
        end
        if (wr && addr) begin
            regs_d.ctrl = wr_ctrl;
            restart = (wr_ctrl.m != regs_q.ctrl.m) ||
                      (wr_ctrl.p != regs_q.ctrl.p) ||
                      (wr_ctrl.s != regs_q.ctrl.s);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign lock_time = regs_q.lock_time;
    assign ctrl      = regs_q.ctrl;
    assign en_next   = regs_d.ctrl.en;

    // R8: divider fields move only on a control write
    a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr) |=> $stable(regs_q.ctrl));
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer
    import pll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              en,
    input  logic              tick,
    input  logic [LOCK_W-1:0] load_val,
    output logic              locked
);
    typedef struct packed {
        logic [LOCK_W-1:0] cnt;
        logic              locked;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.cnt    = load_val;
            tmr_d.locked = 1'b0;
        end else if (!en) begin
            tmr_d.locked = 1'b0;
        end else if (tmr_q.cnt == '0) begin
            tmr_d.locked = 1'b1;
        end else if (tick) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign locked = tmr_q.locked;

    // R4: a divider change reloads the count and drops the flag
    a_r4_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tmr_q.cnt == $past(load_val)) && !tmr_q.locked);

    // R4: the flag only rises after the count has run out
    a_r4_lock_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.locked) |-> ($past(tmr_q.cnt) == '0));

    // R5: no tick, no count movement
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick) |=> $stable(tmr_q.cnt));

    // R6: disabled loop holds its count and reports unlocked
    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !en) |=> $stable(tmr_q.cnt) && !tmr_q.locked);
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
    import pll_pkg::*;
#(
    parameter int unsigned REF_MHZ = 24,
    parameter int unsigned FREQ_W  = 16
) (
    input  pll_ctrl_t         ctrl,
    output logic [FREQ_W-1:0] freq
);
    localparam int unsigned REF_W = $clog2(REF_MHZ + 1);
    localparam int unsigned NUM_W = M_W + REF_W;
    localparam int unsigned DEN_W = P_W + (1 << S_W) - 1;
    localparam int unsigned Q_W   = (NUM_W > DEN_W) ? NUM_W : DEN_W;

    logic [Q_W-1:0] num, den, quo;

    always_comb begin
        num = Q_W'(NUM_W'(ctrl.m) * NUM_W'(REF_MHZ));
        den = Q_W'(DEN_W'(ctrl.p) << ctrl.s);
        quo = (ctrl.p == '0) ? '0 : (num / den);
        freq = FREQ_W'(quo);
    end
endmodule

// File: rtl/pll_cfg_unit.sv
module pll_cfg_unit
    import pll_pkg::*;
#(
    parameter int unsigned REF_MHZ = 24,
    parameter int unsigned FREQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ref_tick,
    output logic              pll_locked,
    output logic [FREQ_W-1:0] freq_mhz
);
    logic [LOCK_W-1:0] lock_time;
    pll_ctrl_t         ctrl;
    logic              en_next;
    logic              restart;
    logic              locked;

    pll_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .lock_time (lock_time),
        .ctrl      (ctrl),
        .en_next   (en_next),
        .restart   (restart)
    );

    pll_lock_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .en       (en_next),
        .tick     (ref_tick),
        .load_val (lock_time),
        .locked   (locked)
    );

    pll_freq_calc #(
        .REF_MHZ (REF_MHZ),
        .FREQ_W  (FREQ_W)
    ) u_freq (
        .ctrl (ctrl),
        .freq (freq_mhz)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata[LOCK_W-1:0] = lock_time;
        end else begin
            bus_rdata[S_LSB +: S_W] = ctrl.s;
            bus_rdata[P_LSB +: P_W] = ctrl.p;
            bus_rdata[M_LSB +: M_W] = ctrl.m;
            bus_rdata[LOCKED_BIT]   = locked;
            bus_rdata[EN_BIT]       = ctrl.en;
        end
    end

    assign pll_locked = locked;

    // R6: stored enable low implies the timer reports unlocked
    a_r6_off_means_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> !locked);
endmodule

// File: tb/pll_cfg_unit_bench.sv
module pll_cfg_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b1;
    logic        pll_locked;
    logic [15:0] freq_mhz;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pll_cfg_unit u_pll_cfg_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_tick  (ref_tick),
        .pll_locked(pll_locked),
        .freq_mhz  (freq_mhz)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input logic en, input int p, input int m, input int s);
        logic [31:0] w;
        w = '0;
        w[31]    = en;
        w[25:16] = m[9:0];
        w[13:8]  = p[5:0];
        w[2:0]   = s[2:0];
        return w;
    endfunction

    function automatic logic [31:0] exp_freq(input int p, input int m, input int s);
        if (p == 0) return 0;
        return (m * 24) / (p << s);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(1'b0, d); check("R1 lock word", d, 32'h0);
        bus_read(1'b1, d); check("R1 control word", d, 32'h0);
        check("R1 locked", {31'b0, pll_locked}, 32'h0);
        check("R1 freq", {16'b0, freq_mhz}, 32'h0);
    endtask

    task automatic t_lock_reg;
        logic [31:0] d;
        bus_write(1'b0, 32'hFFFF_FFFF);
        bus_read(1'b0, d); check("R2 full width", d, 32'h000F_FFFF);
        bus_write(1'b0, 32'hABC1_2345);
        bus_read(1'b0, d); check("R2 pattern", d, 32'h0001_2345);
    endtask

    task automatic t_fields;
        logic [31:0] d;
        // en=0, junk in bits 30, 29, 28:26, 15:14, 7:3
        bus_write(1'b1, mk_ctrl(1'b0, 42, 961, 5) | 32'h7C00_C0F8);
        bus_read(1'b1, d); check("R3 field layout", d, mk_ctrl(1'b0, 42, 961, 5));
        check("R7 bit29 write ignored", {31'b0, d[29]}, 32'h0);
        check("R9 odd fields", {16'b0, freq_mhz}, exp_freq(42, 961, 5));
    endtask

    task automatic t_lock_seq;
        logic [31:0] d;
        bus_write(1'b0, 32'd10);
        bus_write(1'b1, mk_ctrl(1'b1, 3, 175, 0));
        check("R4 cleared at write", {31'b0, pll_locked}, 32'h0);
        step(10);
        check("R4 not before L+1", {31'b0, pll_locked}, 32'h0);
        step(1);
        check("R4 set at L+1", {31'b0, pll_locked}, 32'h1);
        bus_read(1'b1, d);
        check("R10 bit29 matches pin", {31'b0, d[29]}, {31'b0, pll_locked});
        check("R9 1400 MHz point", {16'b0, freq_mhz}, 32'd1400);
    endtask

    task automatic t_same_pms;
        logic [31:0] d;
        bus_write(1'b1, mk_ctrl(1'b1, 3, 175, 0));
        step(1);
        check("R8 rewrite keeps lock", {31'b0, pll_locked}, 32'h1);
        bus_write(1'b1, mk_ctrl(1'b1, 3, 175, 0) & ~32'h2000_0000);
        bus_read(1'b1, d);
        check("R7 clearing bit29 ignored", {31'b0, d[29]}, 32'h1);
        bus_write(1'b1, mk_ctrl(1'b1, 3, 175, 1));
        check("R4 S change drops lock", {31'b0, pll_locked}, 32'h0);
    endtask

    task automatic t_disable;
        logic [31:0] d;
        bus_write(1'b0, 32'd10);
        bus_write(1'b1, mk_ctrl(1'b1, 3, 100, 1));
        step(4);
        bus_write(1'b1, mk_ctrl(1'b0, 3, 100, 1));
        step(1);
        bus_read(1'b1, d);
        check("R6 off reads unlocked", {31'b0, d[29]}, 32'h0);
        step(20);
        check("R6 stays unlocked while off", {31'b0, pll_locked}, 32'h0);
        bus_write(1'b1, mk_ctrl(1'b1, 3, 100, 1));
        step(5);
        check("R6 resume not early", {31'b0, pll_locked}, 32'h0);
        step(1);
        check("R6 resume from held count", {31'b0, pll_locked}, 32'h1);
        bus_write(1'b1, mk_ctrl(1'b0, 3, 100, 1));
        check("R6 disable drops lock", {31'b0, pll_locked}, 32'h0);
    endtask

    task automatic t_tick;
        bus_write(1'b0, 32'd3);
        ref_tick = 1'b0;
        bus_write(1'b1, mk_ctrl(1'b1, 4, 200, 1));
        step(10);
        check("R5 no tick no lock", {31'b0, pll_locked}, 32'h0);
        ref_tick = 1'b1;
        step(3);
        ref_tick = 1'b0;
        check("R5 zero reached not yet locked", {31'b0, pll_locked}, 32'h0);
        step(1);
        check("R5 lock without tick", {31'b0, pll_locked}, 32'h1);
        check("R9 600 MHz point", {16'b0, freq_mhz}, 32'd600);
        ref_tick = 1'b1;
    endtask

    task automatic t_zero_lock;
        bus_write(1'b0, 32'd0);
        bus_write(1'b1, mk_ctrl(1'b1, 3, 125, 0));
        check("R4 zero lock cleared", {31'b0, pll_locked}, 32'h0);
        step(1);
        check("R4 zero lock one edge", {31'b0, pll_locked}, 32'h1);
    endtask

    task automatic t_freq;
        bus_write(1'b1, mk_ctrl(1'b0, 3, 100, 2));
        check("R9 (3,100,2)", {16'b0, freq_mhz}, exp_freq(3, 100, 2));
        bus_write(1'b1, mk_ctrl(1'b0, 3, 100, 0));
        check("R9 (3,100,0)", {16'b0, freq_mhz}, exp_freq(3, 100, 0));
        bus_write(1'b1, mk_ctrl(1'b0, 6, 425, 0));
        check("R9 (6,425,0)", {16'b0, freq_mhz}, 32'd1700);
        bus_write(1'b1, mk_ctrl(1'b0, 3, 200, 0));
        check("R9 (3,200,0)", {16'b0, freq_mhz}, 32'd1600);
        bus_write(1'b1, mk_ctrl(1'b0, 0, 300, 0));
        check("R9 zero P", {16'b0, freq_mhz}, 32'd0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_lock_reg();
        t_fields();
        t_lock_seq();
        t_same_pms();
        t_disable();
        t_tick();
        t_zero_lock();
        t_freq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule